// File: doc/BRIEF.md
# Programmable Audio Sample Delay

This block holds back a stream of audio samples by a chosen number of sample periods. The samples are kept in a circular buffer held in one single-port synchronous RAM. Each sample strobe opens a slot of three clock cycles. In that slot the block first reads the old sample at the read address. It then writes the new sample at the write address, and it puts the old sample on a registered output.

Two address counters walk the buffer, and the RAM address is switched between them. Both counters step once per slot. The delay in samples is how far the write counter leads the read counter. A new delay is applied by reloading the read counter from the write counter minus the requested delay, wrapping around the buffer.

A fill counter records how many samples have been stored since reset. The output stays zero until the slot being read holds a real sample. The buffer is static RAM, so it needs no refresh.

Top module: `audio_delay_line`

## Requirements
- R1: After reset the output is zero, the delay is one sample, and the write counter points at buffer entry 0.
- R2: With delay D in force, the output after the n-th strobe since reset (counting from 0) equals the input sampled at strobe n-D, for n >= D.
- R3: The output changes only at the end of a slot. For a strobe sampled at clock edge e, the new value appears after edge e+2 and is held until the next slot ends.
- R4: While fewer samples have been stored since reset than the current delay, each slot drives a zero output.
- R5: A pulse on the load input sets the delay. The read counter becomes the write counter minus the delay, modulo the buffer depth. Any strobe sampled on a later edge than the load uses the new delay.
- R6: A requested delay of 0 is raised to 1. A requested delay of DEPTH or more is lowered to DEPTH-1. The delay input is ADDR_W+1 bits wide.
- R7: A strobe that arrives while a slot is in progress is ignored. It stores no sample and does not advance either counter.
- R8: A load that arrives during a slot waits until that slot finishes. That slot keeps the old delay, and the new delay is measured from the advanced write counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_strobe | input | 1 | One-cycle pulse that starts a sample slot |
| sample_in | input | DATA_W | Sample to be stored, taken with the strobe |
| delay_set | input | ADDR_W+1 | Requested delay in samples |
| delay_load | input | 1 | Pulse that applies delay_set |
| sample_out | output | DATA_W | Delayed sample, registered |

## Verification
The bench builds the block with an 8-entry buffer (ADDR_W=3) and 16-bit samples. This keeps every legal delay within a short sweep. The sweep covers delays 1 through 7, plus the clamped requests 0, 8 and 15, and pointer wrap happens many times within a few hundred strobes. Because the buffer is small, a reset followed by a long delay also shows the zero-fill phase in full. The bench also checks doubled strobes and loads issued in the middle of a slot against a simple history model.

// File: rtl/audio_delay_line.sv
module audio_delay_line #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_strobe,
  input  logic [DATA_W-1:0] sample_in,
  input  logic [ADDR_W:0]   delay_set,
  input  logic              delay_load,
  output logic [DATA_W-1:0] sample_out
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] MAX_DLY = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W:0]   FULL    = (ADDR_W+1)'(DEPTH);

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} slot_t;
  slot_t state;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ram_q, hold;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr, cur_delay, pend_delay, req_clamped, ram_addr;
  logic [ADDR_W:0]   fill;
  logic              pend_v, ram_we;

  assign req_clamped = (delay_set == '0)   ? ADDR_W'(1) :
                       (delay_set >= FULL) ? MAX_DLY    : delay_set[ADDR_W-1:0];
  assign ram_we   = (state == ST_WR);
  assign ram_addr = (state == ST_RD) ? rd_ptr : wr_ptr;

  always_ff @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= hold;
    ram_q <= mem[ram_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      wr_ptr     <= '0;
      rd_ptr     <= MAX_DLY;
      cur_delay  <= ADDR_W'(1);
      pend_delay <= ADDR_W'(1);
      pend_v     <= 1'b0;
      fill       <= '0;
      hold       <= '0;
      sample_out <= '0;
    end else begin
      if (delay_load) begin
        pend_delay <= req_clamped;
        pend_v     <= 1'b1;
      end
      case (state)
        ST_IDLE: begin
          if (pend_v) begin
            rd_ptr    <= wr_ptr - pend_delay;
            cur_delay <= pend_delay;
            if (!delay_load) pend_v <= 1'b0;
          end
          if (sample_strobe) begin
            hold  <= sample_in;
            state <= ST_RD;
          end
        end
        ST_RD: state <= ST_WR;
        default: begin
          sample_out <= (fill >= {1'b0, cur_delay}) ? ram_q : '0;
          wr_ptr     <= wr_ptr + 1'b1;
          rd_ptr     <= rd_ptr + 1'b1;
          if (fill != FULL) fill <= fill + 1'b1;
          state      <= ST_IDLE;
        end
      endcase
    end
  end

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_WR) |=> $stable(sample_out));

  assert_one_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_WR) |=> $stable(wr_ptr));

  assert_ptr_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR) |=> (wr_ptr == $past(wr_ptr) + 1'b1));

  assert_ptr_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !pend_v) |-> (ADDR_W'(wr_ptr - rd_ptr) == cur_delay));

  assert_delay_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_delay != '0) && (pend_delay != '0));

  assert_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR && fill < {1'b0, cur_delay}) |=> (sample_out == '0));

  assert_fill_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL);
endmodule

// File: tb/audio_delay_line_tb.sv
module audio_delay_line_tb_top;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic [DW-1:0] din = '0;
  logic [AW:0] dset = '0;
  logic dload = 1'b0;
  logic [DW-1:0] dout;

  int errors = 0;
  int checks = 0;
  int wcount = 0;
  int dly = 1;
  logic [DW-1:0] hist [1024];

  always #10 clk = ~clk;

  audio_delay_line #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sample_strobe(strobe), .sample_in(din),
    .delay_set(dset), .delay_load(dload), .sample_out(dout));

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int clamp(input int v);
    if (v == 0) return 1;
    if (v >= DEPTH) return DEPTH - 1;
    return v;
  endfunction

  function automatic logic [DW-1:0] expect_out();
    return (wcount >= dly) ? hist[wcount - dly] : '0;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wcount = 0;
    dly = 1;
  endtask

  task automatic slot(input logic [DW-1:0] v, input string req, input bit twice);
    logic [DW-1:0] prev, exp;
    prev = dout;
    exp = expect_out();
    @(negedge clk);
    strobe = 1'b1; din = v;
    @(negedge clk);
    if (!twice) strobe = 1'b0;
    @(negedge clk);
    strobe = 1'b0;
    check("R3 hold", dout, prev);
    @(negedge clk);
    hist[wcount] = v;
    wcount++;
    check(req, dout, exp);
  endtask

  task automatic load(input int v);
    @(negedge clk);
    dload = 1'b1; dset = (AW+1)'(v);
    @(negedge clk);
    dload = 1'b0;
    dly = clamp(v);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset();
    check("R1 reset", dout, '0);
    slot(16'hA001, "R1 R4 first slot", 1'b0);
    slot(16'hA002, "R1 default delay", 1'b0);
    for (int k = 0; k < 10; k++) slot(DW'(k * 37 + 5), "R2 delay1", 1'b0);

    for (int d = 1; d < DEPTH; d++) begin
      load(d);
      for (int k = 0; k < 20; k++) slot(DW'(d * 1111 + k * 29), "R2 R5 sweep", 1'b0);
    end

    load(0);
    for (int k = 0; k < 12; k++) slot(DW'(k * 91 + 3), "R6 zero clamp", 1'b0);
    load(DEPTH);
    for (int k = 0; k < 12; k++) slot(DW'(k * 53 + 7), "R6 depth clamp", 1'b0);
    load(15);
    for (int k = 0; k < 12; k++) slot(DW'(k * 17 + 9), "R6 max clamp", 1'b0);

    load(3);
    for (int k = 0; k < 10; k++) slot(DW'(k * 71 + 1), "R7 double strobe", 1'b1);

    for (int d = 2; d < DEPTH; d += 2) begin
      logic [DW-1:0] exp;
      exp = expect_out();
      @(negedge clk);
      strobe = 1'b1; din = DW'(d * 7777);
      @(negedge clk);
      strobe = 1'b0; dload = 1'b1; dset = (AW+1)'(d);
      @(negedge clk);
      dload = 1'b0;
      @(negedge clk);
      hist[wcount] = DW'(d * 7777);
      wcount++;
      check("R8 old delay kept", dout, exp);
      dly = d;
      for (int k = 0; k < 9; k++) slot(DW'(d * 313 + k * 3), "R8 new delay", 1'b0);
    end

    do_reset();
    check("R1 second reset", dout, '0);
    load(6);
    for (int k = 0; k < 14; k++) slot(DW'(k * 131 + 11), "R4 zero fill", 1'b0);
    load(7);
    for (int k = 0; k < 10; k++) slot(DW'(k * 19 + 2), "R4 R5 lengthened", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule